// File: doc/BRIEF.md
# Three-Wire Codec Control Write Master

This block drives a write-only serial control link made of three lines: a bit clock, a data line and a mode line. Audio codecs and similar peripherals take their configuration over such a link. The host supplies three things: an address byte, a byte count and the six timing values. It then pulses `start`. The master performs the whole transfer by itself and asks for each data byte through a valid/ready handshake.

A transfer has two phases. In the address phase the mode line is low. In the data phase the mode line is high while each byte is sent. Between two data bytes the mode line drops low for a programmed time. It never drops before the first data byte or after the last one. Every byte leaves least significant bit first, and the slave samples data on the rising clock edge.

Each wait is a count of system-clock cycles. A programmed value of zero counts as one cycle. The six timing values are captured when a transfer is accepted. `busy` marks the transfer. A one-cycle `done` marks its end.

Top module: `tw_ctl_writer`

## Requirements
- R1: Out of reset and whenever idle, the bus rests at clock high, data high and mode low, with `busy`, `done` and `wr_ready` low.
- R2: An accepted start first drives clock, data and mode all high for the mode-pulse time. It then drives mode low for the mode-setup time before the first bit.
- R3: Each bit takes three steps. Clock goes low with data unchanged for the data-hold time. The new data bit then appears with clock still low for the data-setup time. Clock then goes high for the clock-high time. Bits go out LSB first.
- R4: The address byte is shifted with mode low. A mode-hold wait with mode still low follows it.
- R5: Each data byte is preceded by mode rising, with clock high, and held for the mode-setup time. Mode stays high while that byte's bits are shifted.
- R6: Between consecutive data bytes the master waits the mode-hold time with mode high, then holds mode low for the mode-pulse time. No such low pulse comes before the first data byte or after the last.
- R7: Before each data byte `wr_ready` is high and the bus lines are frozen, with clock high and mode low. The byte is taken on the cycle where `wr_valid` and `wr_ready` are both high.
- R8: A byte count of zero sends the address phase and its mode-hold wait, then ends the transfer.
- R9: Every timing value of zero is treated as one cycle. The timing values are sampled when start is accepted, so later changes do not affect the running transfer.
- R10: A start pulse while `busy` is high, including the final cycle, is ignored.
- R11: The transfer ends with one cycle in which `done` and `busy` are high and the lines already show clock high, data high and mode low. The next cycle is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a transfer (honoured only when idle) |
| addr | input | 8 | Address byte, sampled at start |
| count | input | CNT_W | Number of data bytes, sampled at start |
| t_dhold | input | TW | Clock-low time before the data bit changes |
| t_dsetup | input | TW | Data-valid time before the rising clock |
| t_chigh | input | TW | Clock-high time per bit |
| t_mhold | input | TW | Wait after a byte before mode changes |
| t_mpulse | input | TW | Mode-high preamble and inter-byte mode-low pulse width |
| t_msetup | input | TW | Mode settle time before a byte |
| wr_data | input | DATA_W | Next data byte |
| wr_valid | input | 1 | `wr_data` is valid |
| wr_ready | output | 1 | Master is waiting for a data byte |
| bus_clk | output | 1 | Serial clock line |
| bus_dat | output | 1 | Serial data line |
| bus_mode | output | 1 | Mode line |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer strobe |

## Verification
A wrong phase or a wrong counter value shows up on the three bus lines in the very cycle it takes effect. The reference trace fixes the value of every line in every cycle, so a wait that is one cycle too long or too short shifts every later cycle and is reported at once. A lost or misordered data byte changes `bus_dat` during the setup step of the first affected bit. An inter-byte mode pulse that is missing or added appears as a mode mismatch before the next byte starts. A start that is not ignored shows up one cycle later as a transfer restarting its preamble.

// File: rtl/tw_ctl_pkg.sv
package tw_ctl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,    // all lines high, mode-pulse time
    ST_SETUP,  // mode low before address
    ST_BLOW,   // clock low, data held
    ST_BDAT,   // clock low, new bit shown
    ST_BHIGH,  // clock high
    ST_HOLD,   // post-byte mode-hold
    ST_PULSE,  // inter-byte mode low
    ST_FETCH,  // waiting for a data byte
    ST_RAISE,  // mode high before a data byte
    ST_END     // rest levels, done strobe
  } seq_t;

  // zero counts as one cycle
  function automatic logic [7:0] eff_wait(input logic [7:0] v);
    return (v == 8'd0) ? 8'd1 : v;
  endfunction

endpackage

// File: rtl/tw_ctl_timer.sv
module tw_ctl_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  localparam logic [W-1:0] ONE = 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= len - ONE;
    else if (cnt != '0)    cnt <= cnt - ONE;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/tw_ctl_shifter.sv
module tw_ctl_shifter #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] din,
  input  logic          shift,
  output logic          bit_out,
  output logic          last
);
  localparam int IW = $clog2(BW);
  localparam logic [IW-1:0] LAST_IDX = IW'(BW - 1);
  localparam logic [IW-1:0] ONE      = 1;

  logic [BW-1:0] sr;
  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      idx <= '0;
    end else if (load) begin
      sr  <= din;
      idx <= '0;
    end else if (shift) begin
      sr  <= sr >> 1;
      idx <= idx + ONE;
    end
  end

  assign bit_out = sr[0];
  assign last    = (idx == LAST_IDX);
endmodule

// File: rtl/tw_ctl_writer.sv
module tw_ctl_writer
  import tw_ctl_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int TW     = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        addr,
  input  logic [CNT_W-1:0]  count,
  input  logic [TW-1:0]     t_dhold,
  input  logic [TW-1:0]     t_dsetup,
  input  logic [TW-1:0]     t_chigh,
  input  logic [TW-1:0]     t_mhold,
  input  logic [TW-1:0]     t_mpulse,
  input  logic [TW-1:0]     t_msetup,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic              bus_clk,
  output logic              bus_dat,
  output logic              bus_mode,
  output logic              busy,
  output logic              done
);
  localparam logic [TW-1:0]    T_ONE = 1;
  localparam logic [CNT_W-1:0] C_ONE = 1;

  function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
    return (v == '0) ? T_ONE : v;
  endfunction

  seq_t state, nxt;
  logic              in_addr;
  logic [CNT_W-1:0]  remain;
  logic              dat_r;
  logic [TW-1:0]     w_dh, w_ds, w_ch, w_mh, w_mt, w_ms;

  logic              tmr_load, tmr_exp;
  logic [TW-1:0]     tmr_len;
  logic              sh_load, sh_shift, sh_bit, sh_last;
  logic [DATA_W-1:0] sh_din;

  // named internal events
  logic ev_accept, ev_take, ev_byte_end;
  assign ev_accept   = (state == ST_IDLE) && start;
  assign ev_take     = (state == ST_FETCH) && wr_valid;
  assign ev_byte_end = (state == ST_BHIGH) && tmr_exp && sh_last;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (start) nxt = ST_PRE;
      ST_PRE:   if (tmr_exp) nxt = ST_SETUP;
      ST_SETUP: if (tmr_exp) nxt = ST_BLOW;
      ST_BLOW:  if (tmr_exp) nxt = ST_BDAT;
      ST_BDAT:  if (tmr_exp) nxt = ST_BHIGH;
      ST_BHIGH: if (tmr_exp) begin
        if (!sh_last)                        nxt = ST_BLOW;
        else if (in_addr || remain != '0)    nxt = ST_HOLD;
        else                                 nxt = ST_END;
      end
      ST_HOLD:  if (tmr_exp) begin
        if (!in_addr)            nxt = ST_PULSE;
        else if (remain == '0)   nxt = ST_END;
        else                     nxt = ST_FETCH;
      end
      ST_PULSE: if (tmr_exp) nxt = ST_FETCH;
      ST_FETCH: if (wr_valid) nxt = ST_RAISE;
      ST_RAISE: if (tmr_exp) nxt = ST_BLOW;
      ST_END:   nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    case (nxt)
      ST_PRE:   tmr_len = at_least_one(t_mpulse);
      ST_SETUP: tmr_len = w_ms;
      ST_BLOW:  tmr_len = w_dh;
      ST_BDAT:  tmr_len = w_ds;
      ST_BHIGH: tmr_len = w_ch;
      ST_HOLD:  tmr_len = w_mh;
      ST_PULSE: tmr_len = w_mt;
      ST_RAISE: tmr_len = w_ms;
      default:  tmr_len = T_ONE;
    endcase
  end

  assign tmr_load = (nxt != state);
  assign sh_load  = ev_accept || ev_take;
  assign sh_din   = ev_accept ? DATA_W'(addr) : wr_data;
  assign sh_shift = (state == ST_BHIGH) && tmr_exp && !sh_last;

  tw_ctl_timer #(.W(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .len     (tmr_len),
    .expired (tmr_exp)
  );

  tw_ctl_shifter #(.BW(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (sh_load),
    .din     (sh_din),
    .shift   (sh_shift),
    .bit_out (sh_bit),
    .last    (sh_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      in_addr <= 1'b0;
      remain  <= '0;
      dat_r   <= 1'b1;
      w_dh    <= T_ONE;
      w_ds    <= T_ONE;
      w_ch    <= T_ONE;
      w_mh    <= T_ONE;
      w_mt    <= T_ONE;
      w_ms    <= T_ONE;
    end else begin
      state <= nxt;
      if (ev_accept) begin
        in_addr <= 1'b1;
        remain  <= count;
        dat_r   <= 1'b1;
        w_dh    <= at_least_one(t_dhold);
        w_ds    <= at_least_one(t_dsetup);
        w_ch    <= at_least_one(t_chigh);
        w_mh    <= at_least_one(t_mhold);
        w_mt    <= at_least_one(t_mpulse);
        w_ms    <= at_least_one(t_msetup);
      end
      if (ev_take) begin
        in_addr <= 1'b0;
        remain  <= remain - C_ONE;
      end
      if (state == ST_BLOW && tmr_exp) dat_r <= sh_bit;
      if (nxt == ST_END)               dat_r <= 1'b1;
    end
  end

  always_comb begin
    case (state)
      ST_PRE, ST_RAISE:          bus_mode = 1'b1;
      ST_BLOW, ST_BDAT, ST_BHIGH,
      ST_HOLD:                   bus_mode = !in_addr;
      default:                   bus_mode = 1'b0;
    endcase
  end

  assign bus_clk  = !(state == ST_BLOW || state == ST_BDAT);
  assign bus_dat  = dat_r;
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_END);
  assign wr_ready = (state == ST_FETCH);
endmodule

// File: rtl/tw_ctl_writer_chk.sv
module tw_ctl_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic wr_ready,
  input logic wr_valid,
  input logic bus_clk,
  input logic bus_dat,
  input logic bus_mode,
  input logic ev_accept,
  input logic ev_byte_end
);
  AST_REST_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_clk && bus_dat && !bus_mode)); // R1

  AST_START_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (busy && bus_clk && bus_dat && bus_mode)); // R2

  AST_DAT_STILL_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_clk && $past(bus_clk) && busy && $past(busy) && !done) |-> $stable(bus_dat)); // R3

  AST_BYTE_END_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte_end |-> (bus_clk && busy)); // R3

  AST_MODE_RISE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_mode) |-> bus_clk); // R5

  AST_READY_MODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (busy && bus_clk && !bus_mode)); // R7

  AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !wr_valid) |=> (wr_ready && $stable({bus_clk, bus_dat, bus_mode}))); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R11

  AST_DONE_REST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && bus_clk && bus_dat && !bus_mode)); // R11
endmodule

bind tw_ctl_writer tw_ctl_writer_chk u_chk (.*);

// File: tb/tw_ctl_writer_test.sv
`timescale 1ns/1ps
module tw_ctl_writer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] addr = 8'h00, count = 8'h00;
  logic [7:0] t_dhold = 8'd1, t_dsetup = 8'd1, t_chigh = 8'd1;
  logic [7:0] t_mhold = 8'd1, t_mpulse = 8'd1, t_msetup = 8'd1;
  logic [7:0] wr_data = 8'h00;
  logic       wr_valid = 1'b0;
  logic       wr_ready, bus_clk, bus_dat, bus_mode, busy, done;

  always #2 clk = ~clk;  // 250 MHz

  tw_ctl_writer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .count(count),
    .t_dhold(t_dhold), .t_dsetup(t_dsetup), .t_chigh(t_chigh),
    .t_mhold(t_mhold), .t_mpulse(t_mpulse), .t_msetup(t_msetup),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .bus_clk(bus_clk), .bus_dat(bus_dat), .bus_mode(bus_mode),
    .busy(busy), .done(done)
  );

  typedef struct packed {
    logic c, d, m, b, r, dn;
    logic [7:0] tag;
  } exp_t;

  exp_t       q[$];
  logic [7:0] feed_q[$];
  int         gap = 0, scen = 1, checks = 0, errors = 0;
  bit         mon_en = 0;
  bit         cur_d;

  function automatic string rname(int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";
      4: return "R4";   5: return "R5";   6: return "R6";
      7: return "R7";   8: return "R8";   9: return "R9";
      10: return "R10"; 11: return "R11";
      default: return "R?";
    endcase
  endfunction

  function automatic int eff(int v);
    if (v == 0) return 1;
    return v;
  endfunction

  function automatic void push(bit c, bit d, bit m, bit b, bit r, bit dn, int n, int tag);
    exp_t e;
    e.c = c; e.d = d; e.m = m; e.b = b; e.r = r; e.dn = dn; e.tag = 8'(tag);
    for (int i = 0; i < n; i++) q.push_back(e);
  endfunction

  function automatic void put_byte(logic [7:0] v, bit m, int dh, int ds, int ch, int tag);
    for (int i = 0; i < 8; i++) begin       // LSB first, R3
      push(0, cur_d, m, 1, 0, 0, eff(dh), 3);
      cur_d = v[i];
      push(0, cur_d, m, 1, 0, 0, eff(ds), 3);
      push(1, cur_d, m, 1, 0, 0, eff(ch), tag);
    end
  endfunction

  function automatic void build(logic [7:0] a, int cnt, int dh, int ds, int ch,
                                int mh, int mt, int ms);
    push(1, 1, 0, 0, 0, 0, 1, 1);            // cycle before start is seen
    cur_d = 1;
    push(1, 1, 1, 1, 0, 0, eff(mt), 2);      // preamble, R2
    push(1, 1, 0, 1, 0, 0, eff(ms), 2);
    put_byte(a, 0, dh, ds, ch, 4);           // address, R4
    push(1, cur_d, 0, 1, 0, 0, eff(mh), 4);
    for (int j = 0; j < cnt; j++) begin
      if (j > 0) begin                        // inter-byte pulse, R6
        push(1, cur_d, 1, 1, 0, 0, eff(mh), 6);
        push(1, cur_d, 0, 1, 0, 0, eff(mt), 6);
      end
      push(1, cur_d, 0, 1, 1, 0, gap + 1, 7); // fetch wait, R7
      push(1, cur_d, 1, 1, 0, 0, eff(ms), 5); // R5
      put_byte(feed_q[j], 1, dh, ds, ch, 5);
    end
    push(1, 1, 0, 1, 0, 1, 1, 11);           // R11
  endfunction

  // per-cycle comparison against the reference trace
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en) begin
        exp_t e;
        logic [5:0] got, want;
        if (q.size() > 0) e = q.pop_front();
        else begin
          e.c = 1; e.d = 1; e.m = 0; e.b = 0; e.r = 0; e.dn = 0; e.tag = 8'd1;
        end
        got  = {bus_clk, bus_dat, bus_mode, busy, wr_ready, done};
        want = {e.c, e.d, e.m, e.b, e.r, e.dn};
        checks++;
        if (got !== want) begin
          errors++;
          $display("FAIL %s (case %s) @%0t clk/dat/mode/busy/ready/done got=%b expected=%b",
                   rname(int'(e.tag)), rname(scen), $time, got, want);
        end
      end
    end
  end

  // data byte supplier with a programmable delay after ready
  initial begin
    int gcnt = 0;
    forever begin
      @(negedge clk);
      if (wr_ready) begin
        if (!wr_valid) begin
          if (gcnt >= gap) begin
            wr_data  = feed_q.pop_front();
            wr_valid = 1'b1;
          end else gcnt++;
        end
      end else begin
        wr_valid = 1'b0;
        gcnt = 0;
      end
    end
  end

  task automatic run(int sc, logic [7:0] a, int cnt, int dh, int ds, int ch,
                     int mh, int mt, int ms, int g, int poke);
    int len;
    scen = sc;
    gap  = g;
    @(posedge clk); #1;
    build(a, cnt, dh, ds, ch, mh, mt, ms);
    len = q.size();
    addr = a; count = 8'(cnt);
    t_dhold = 8'(dh); t_dsetup = 8'(ds); t_chigh = 8'(ch);
    t_mhold = 8'(mh); t_mpulse = 8'(mt); t_msetup = 8'(ms);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    // inputs change after acceptance: must not matter (R9)
    addr = 8'hFF; count = 8'd3;
    t_dhold = 8'd7; t_dsetup = 8'd7; t_chigh = 8'd7;
    t_mhold = 8'd7; t_mpulse = 8'd7; t_msetup = 8'd7;
    if (poke != 0) begin                      // R10: start while busy
      int p = (poke < 0) ? len - 2 : poke;
      repeat (p) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    while (q.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;  // R1 reset levels
    if ({bus_clk, bus_dat, bus_mode, busy, wr_ready, done} !== 6'b110000) begin
      errors++;
      $display("FAIL R1 reset got=%b expected=110000",
               {bus_clk, bus_dat, bus_mode, busy, wr_ready, done});
    end
    rst_n = 1'b1;
    mon_en = 1;

    feed_q = '{8'hA5};                                   // R3, R4, R5
    run(3, 8'h16, 1, 1, 1, 1, 1, 1, 1, 0, 0);
    feed_q = '{8'h3C, 8'h81, 8'h7E};                     // R6
    run(6, 8'h2B, 3, 2, 3, 1, 2, 4, 3, 2, 0);
    feed_q = '{};                                        // R8
    run(8, 8'hC9, 0, 3, 2, 2, 3, 2, 2, 0, 0);
    feed_q = '{8'h55, 8'hF0};                            // R9
    run(9, 8'h81, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    feed_q = '{8'h0F, 8'hE1};                            // R7
    run(7, 8'h44, 2, 1, 2, 2, 1, 3, 1, 5, 0);
    feed_q = '{8'h12, 8'h34};                            // R10 mid-transfer
    run(10, 8'h5A, 2, 1, 1, 2, 1, 2, 1, 1, 20);
    feed_q = '{8'h99};                                   // R10 on final cycle
    run(10, 8'hA3, 1, 2, 1, 1, 2, 1, 2, 0, -1);
    feed_q = '{8'h01, 8'h80, 8'hFF, 8'h00};              // R2, R11
    run(11, 8'h7F, 4, 1, 1, 3, 2, 1, 2, 1, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule